// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits beside a serial-port peripheral and turns that peripheral's interrupt events into a processor interrupt. Each event pulse sets a sticky bit in a status register. The status register is gated by an enable mask. Whenever an enabled bit is pending, the block pulls its active-low request line low. When the processor answers with an active-low acknowledge cycle, the block returns an 8-bit vector. A two-bit mode field builds this vector from a programmable base value, a one-bit channel code and a two-bit code that names the kind of source being served.

The same handshake engine also serves ordinary bus accesses through an active-low access strobe. In both cases the active-low data-acknowledge strobe goes low after a configurable number of clock cycles. It stays low until the request input returns high. The status register can be read in two ways, selected by a configuration bit: raw, or filtered through the enable mask.

Configuration is loaded in one cycle through `cfg_we`. The fields are: vector mode, read-filter bit, enable mask and vector base.

Acknowledge engine states and transitions:
- `ST_IDLE`: no cycle is active.
- `ST_WAIT`: latency countdown. The data-acknowledge strobe is still high.
- `ST_ACK`: the data-acknowledge strobe is low.
- Transitions:
  - *start* (`ST_IDLE`→`ST_WAIT`): the acknowledge or access input is seen low. The vector is captured here.
  - *expire* (`ST_WAIT`→`ST_ACK`): the countdown reaches zero.
  - *abort* (`ST_WAIT`→`ST_IDLE`): both inputs go high before the countdown expires.
  - *release* (`ST_ACK`→`ST_IDLE`): both inputs are high again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the vector mode, read-filter bit, enable mask and vector base are all zero; `irq_n` and `dack_n` are 1 and `data_bus` reads 0xFF. Setting a source while the mask is zero leaves `irq_n` at 1.
- R2: With vector mode 2'b00, `data_bus` reads 0xFF throughout an acknowledge cycle.
- R3: With vector mode 2'b01, the vector equals the 8-bit base unchanged.
- R4: With vector mode 2'b10, the vector is {base[7:1], chan_id}.
- R5: With vector mode 2'b11, the vector is {base[7:3], type[1:0], chan_id}.
- R6: Source bit 0 is a receive error, bit 1 is receive data without error, bit 2 is transmit, and higher bits are other sources. The type code is taken over sources that are both pending and enabled. Receive error gives 2'b11, receive data gives 2'b10, transmit gives 2'b01, and anything else (or nothing pending) gives 2'b00. Priority runs in that order.
- R7: When the read-filter bit is 1, `isr_rd_data` equals status AND mask. When it is 0, `isr_rd_data` equals the raw status.
- R8: `irq_n` is 0 exactly when status AND mask is nonzero, whatever the read-filter bit says.
- R9: The vector is captured in the cycle the acknowledge input is first sampled low. It is held on `data_bus` until that input rises, even if the base changes meanwhile.
- R10: `dack_n` goes low ACK_DLY clock edges after the edge that first samples `iack_n` or `acc_n` low. It returns high on the edge after both inputs are sampled high.
- R11: A `src_set` bit sets its status bit and a `src_clr` bit clears it; when both strike the same bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | NSRC | Per-source event pulses |
| src_clr | input | NSRC | Per-source status clear pulses |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_vmode | input | 2 | Vector composition mode |
| cfg_rdmask | input | 1 | Read-filter bit for the status view |
| cfg_imr | input | NSRC | Source enable mask |
| cfg_ivr | input | 8 | Vector base |
| chan_id | input | 1 | Channel code inserted into the vector |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| acc_n | input | 1 | Active-low ordinary bus access |
| isr_rd_data | output | NSRC | Status read view |
| irq_n | output | 1 | Active-low interrupt request |
| data_bus | output | 8 | Vector during acknowledge, else 0xFF |
| data_oe | output | 1 | High while a vector is driven |
| dack_n | output | 1 | Active-low data acknowledge |

## Verification
The bench builds the block with NSRC = 6 and ACK_DLY = 3. Six sources leave three "other" bits above the three typed ones, so priority between typed and untyped sources can be exercised. A three-cycle latency makes the edge before `dack_n` falls distinguishable from the edge on which it falls. The same latency leaves a window in which the base can be rewritten mid-cycle to show that the captured vector holds.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } ack_state_t;

    localparam int SRC_RXERR = 0;
    localparam int SRC_RXOK  = 1;
    localparam int SRC_TX    = 2;

    localparam logic [1:0] VM_NONE  = 2'b00;
    localparam logic [1:0] VM_BASE  = 2'b01;
    localparam logic [1:0] VM_CHAN  = 2'b10;
    localparam logic [1:0] VM_TYPED = 2'b11;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    input  logic [NSRC-1:0] imr,
    input  logic            rdmask,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] pending,
    output logic [NSRC-1:0] rd_view
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            // set has priority over clear
            status <= (status & ~src_clr) | src_set;
        end
    end

    always_comb begin
        pending = status & imr;
        rd_view = rdmask ? pending : status;
    end
endmodule

// File: rtl/irq_vec_compose.sv
module irq_vec_compose
    import irq_vector_pkg::*;
(
    input  logic [1:0] vmode,
    input  logic [7:0] base,
    input  logic       chan,
    input  logic [2:0] pend_typed,
    output logic [7:0] vec
);
    logic [1:0] kind;

    always_comb begin
        if (pend_typed[SRC_RXERR])     kind = 2'b11;
        else if (pend_typed[SRC_RXOK]) kind = 2'b10;
        else if (pend_typed[SRC_TX])   kind = 2'b01;
        else                           kind = 2'b00;
    end

    always_comb begin
        unique case (vmode)
            VM_NONE:  vec = 8'hFF;
            VM_BASE:  vec = base;
            VM_CHAN:  vec = {base[7:1], chan};
            VM_TYPED: vec = {base[7:3], kind, chan};
        endcase
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_vector_pkg::*;
#(
    parameter int ACK_DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iack_n,
    input  logic       acc_n,
    input  logic [7:0] vec_in,
    output logic [7:0] data_bus,
    output logic       data_oe,
    output logic       dack_n,
    output ack_state_t state
);
    localparam int CW = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY);

    ack_state_t nxt;
    logic [CW-1:0] cnt;
    logic [7:0]    vec_q;
    logic          is_iack;
    logic          req_any;

    assign req_any = !iack_n || !acc_n;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_any) nxt = ST_WAIT;                 // start
            ST_WAIT: if (!req_any) nxt = ST_IDLE;                // abort
                     else if (cnt == '0) nxt = ST_ACK;           // expire
            ST_ACK:  if (!req_any) nxt = ST_IDLE;                // release
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            vec_q   <= 8'hFF;
            is_iack <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_any) begin
                cnt     <= CW'(ACK_DLY - 1);
                is_iack <= !iack_n;
                vec_q   <= vec_in;
            end else if (state == ST_WAIT && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        dack_n   = (state != ST_ACK);
        data_oe  = (state != ST_IDLE) && is_iack;
        data_bus = data_oe ? vec_q : 8'hFF;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int NSRC    = 6,
    parameter int ACK_DLY = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_vmode,
    input  logic            cfg_rdmask,
    input  logic [NSRC-1:0] cfg_imr,
    input  logic [7:0]      cfg_ivr,
    input  logic            chan_id,
    input  logic            iack_n,
    input  logic            acc_n,
    output logic [NSRC-1:0] isr_rd_data,
    output logic            irq_n,
    output logic [7:0]      data_bus,
    output logic            data_oe,
    output logic            dack_n
);
    logic [1:0]      vmode_q;
    logic            rdmask_q;
    logic [NSRC-1:0] imr_q;
    logic [7:0]      ivr_q;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] pending;
    logic [7:0]      vec_now;
    ack_state_t      fsm_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmode_q  <= 2'b00;
            rdmask_q <= 1'b0;
            imr_q    <= '0;
            ivr_q    <= 8'h00;
        end else if (cfg_we) begin
            vmode_q  <= cfg_vmode;
            rdmask_q <= cfg_rdmask;
            imr_q    <= cfg_imr;
            ivr_q    <= cfg_ivr;
        end
    end

    irq_status_bank #(.NSRC(NSRC)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_set (src_set),
        .src_clr (src_clr),
        .imr     (imr_q),
        .rdmask  (rdmask_q),
        .status  (status),
        .pending (pending),
        .rd_view (isr_rd_data)
    );

    irq_vec_compose u_comp (
        .vmode      (vmode_q),
        .base       (ivr_q),
        .chan       (chan_id),
        .pend_typed (pending[2:0]),
        .vec        (vec_now)
    );

    irq_ack_fsm #(.ACK_DLY(ACK_DLY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .iack_n   (iack_n),
        .acc_n    (acc_n),
        .vec_in   (vec_now),
        .data_bus (data_bus),
        .data_oe  (data_oe),
        .dack_n   (dack_n),
        .state    (fsm_st)
    );

    assign irq_n = (pending == '0);
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vector_pkg::*;
#(
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_set,
    input logic            cfg_we,
    input logic [NSRC-1:0] imr_q,
    input logic            rdmask_q,
    input logic [NSRC-1:0] isr_rd_data,
    input logic            irq_n,
    input logic [7:0]      data_bus,
    input logic            data_oe,
    input logic            dack_n,
    input logic            iack_n,
    input logic            acc_n,
    input ack_state_t      fsm_st
);
    // R8: an enabled source event raises the request on the next edge
    p_irq_on_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_set & imr_q)) && !cfg_we |=> !irq_n);

    // R7: filtered view is empty while no request is raised
    p_masked_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdmask_q && irq_n |-> isr_rd_data == '0);

    // R9: vector stays put while it is driven
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe && $past(data_oe) |-> $stable(data_bus));

    // R10: strobe is released after both inputs are high
    p_dack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iack_n && acc_n |=> dack_n);

    // R10: strobe falls only out of the countdown state
    p_dack_after_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dack_n) |-> $past(fsm_st) == ST_WAIT);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_set     (src_set),
    .cfg_we      (cfg_we),
    .imr_q       (imr_q),
    .rdmask_q    (rdmask_q),
    .isr_rd_data (isr_rd_data),
    .irq_n       (irq_n),
    .data_bus    (data_bus),
    .data_oe     (data_oe),
    .dack_n      (dack_n),
    .iack_n      (iack_n),
    .acc_n       (acc_n),
    .fsm_st      (fsm_st)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int NSRC = 6;
    localparam int D    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_set = '0, src_clr = '0, cfg_imr = '0;
    logic cfg_we = 1'b0, cfg_rdmask = 1'b0, chan_id = 1'b0;
    logic [1:0] cfg_vmode = 2'b00;
    logic [7:0] cfg_ivr = 8'h00;
    logic iack_n = 1'b1, acc_n = 1'b1;
    logic [NSRC-1:0] isr_rd_data;
    logic irq_n, data_oe, dack_n;
    logic [7:0] data_bus;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.NSRC(NSRC), .ACK_DLY(D)) uut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .cfg_we(cfg_we), .cfg_vmode(cfg_vmode), .cfg_rdmask(cfg_rdmask),
        .cfg_imr(cfg_imr), .cfg_ivr(cfg_ivr), .chan_id(chan_id),
        .iack_n(iack_n), .acc_n(acc_n), .isr_rd_data(isr_rd_data),
        .irq_n(irq_n), .data_bus(data_bus), .data_oe(data_oe), .dack_n(dack_n)
    );

    // {vmode, base, chan, imr, sources, expected vector}
    localparam logic [30:0] TBL [11] = '{
        {2'd0, 8'hA5, 1'b1, 6'h3F, 6'h01, 8'hFF},   // R2
        {2'd1, 8'hA5, 1'b1, 6'h3F, 6'h04, 8'hA5},   // R3
        {2'd2, 8'hA4, 1'b1, 6'h3F, 6'h02, 8'hA5},   // R4
        {2'd3, 8'hFF, 1'b0, 6'h3F, 6'h01, 8'hFE},   // R5 R6 rx error
        {2'd3, 8'h00, 1'b1, 6'h3F, 6'h02, 8'h05},   // R6 rx ok
        {2'd3, 8'h00, 1'b0, 6'h3F, 6'h04, 8'h02},   // R6 tx
        {2'd3, 8'h00, 1'b0, 6'h3F, 6'h08, 8'h00},   // R6 other
        {2'd3, 8'hE8, 1'b1, 6'h3F, 6'h07, 8'hEF},   // R6 priority
        {2'd3, 8'hE8, 1'b1, 6'h3F, 6'h06, 8'hED},   // R6 priority
        {2'd3, 8'h00, 1'b0, 6'h3E, 6'h05, 8'h02},   // R6 masked error
        {2'd3, 8'h18, 1'b0, 6'h3F, 6'h00, 8'h18}    // R5 base 4:3 kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic configure(input logic [1:0] vm, input logic rm,
                             input logic [NSRC-1:0] m, input logic [7:0] b);
        cfg_vmode = vm; cfg_rdmask = rm; cfg_imr = m; cfg_ivr = b; cfg_we = 1'b1;
        cycles(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_set(input logic [NSRC-1:0] s);
        src_set = s; cycles(1); src_set = '0;
    endtask

    task automatic clear_all();
        src_clr = '1; cycles(1); src_clr = '0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cycles(3);
        // R1 reset state
        check("R1 irq_n", 32'(irq_n), 1);
        check("R1 dack_n", 32'(dack_n), 1);
        check("R1 data_bus", 32'(data_bus), 32'hFF);
        rst_n = 1'b1;
        cycles(1);
        pulse_set(6'h07);
        check("R1 mask cleared keeps irq_n high", 32'(irq_n), 1);
        check("R1 raw status visible", 32'(isr_rd_data), 32'h07);
        iack_n = 1'b0; cycles(D + 1);
        check("R1 mode cleared gives 0xFF", 32'(data_bus), 32'hFF);
        iack_n = 1'b1; cycles(1);
        clear_all();

        // table walk
        foreach (TBL[k]) begin
            configure(TBL[k][30:29], 1'b0, TBL[k][19:14], TBL[k][28:21]);
            chan_id = TBL[k][20];
            pulse_set(TBL[k][13:8]);
            check("R8 irq_n", 32'(irq_n), 32'((TBL[k][13:8] & TBL[k][19:14]) == 0));
            iack_n = 1'b0; cycles(D + 1);
            check("R2-5 R6 vector", 32'(data_bus), 32'(TBL[k][7:0]));
            iack_n = 1'b1; cycles(1);
            check("R10 release", 32'(dack_n), 1);
            clear_all();
        end

        // R10 latency
        configure(2'd1, 1'b0, 6'h3F, 8'h3C);
        iack_n = 1'b0; cycles(D);
        check("R10 dack_n high before latency", 32'(dack_n), 1);
        check("R9 vector captured early", 32'(data_bus), 32'h3C);
        cycles(1);
        check("R10 dack_n low at latency", 32'(dack_n), 0);
        // R9 base change mid-cycle does not disturb vector
        configure(2'd1, 1'b0, 6'h3F, 8'hC3);
        cycles(2);
        check("R9 vector held", 32'(data_bus), 32'h3C);
        check("R10 dack_n held", 32'(dack_n), 0);
        iack_n = 1'b1; cycles(1);
        check("R10 dack_n released", 32'(dack_n), 1);
        check("R9 bus idle after release", 32'(data_bus), 32'hFF);

        // R10 plain access
        acc_n = 1'b0; cycles(D + 1);
        check("R10 access dack_n", 32'(dack_n), 0);
        check("R10 access no vector", 32'(data_oe), 0);
        acc_n = 1'b1; cycles(1);
        check("R10 access release", 32'(dack_n), 1);

        // R7 read filter
        configure(2'd3, 1'b1, 6'h0A, 8'h00);
        pulse_set(6'h0C);
        check("R7 filtered view", 32'(isr_rd_data), 32'h08);
        check("R8 irq with filter on", 32'(irq_n), 0);
        configure(2'd3, 1'b0, 6'h0A, 8'h00);
        check("R7 raw view", 32'(isr_rd_data), 32'h0C);
        check("R8 irq with filter off", 32'(irq_n), 0);
        clear_all();
        check("R8 irq drops after clear", 32'(irq_n), 1);

        // R11 set beats clear
        src_set = 6'h02; src_clr = 6'h02; cycles(1);
        src_set = '0; src_clr = '0;
        check("R11 set wins", 32'(isr_rd_data), 32'h02);
        src_clr = 6'h02; cycles(1); src_clr = '0;
        check("R11 clear", 32'(isr_rd_data), 32'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule